// File: doc/BRIEF.md
# Dual Watchdog Reset Supervisor

This block watches a host processor through two independent watchdog timers, one short and one long. Each timer has its own refresh input. Any change of level on a refresh input counts as a refresh and reloads only that timer. When a timer runs out, or when a manual reset or a power-on request arrives, the block pulls its active-low system reset low. The reset stays low for a minimum width, and both timers start again from zero when it is released.

A status output records what caused the last reset. It reads high after a short-watchdog timeout or a power-on request, and low after a long-watchdog timeout. The low indication returns to high by itself once a programmable clear interval has elapsed. The short watchdog can be switched off by leaving its refresh input floating; a detector outside the block reports that condition as a digital flag. A lock input, meant to be tied low when not used, can forbid that switch-off. All time intervals are counted in ticks of an internal reference prescaler. The sizes of the prescaler and of every interval are parameters.

Top module: `wdsup_top`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is low and `cause_stat` is high. The system reset is still low in the cycle right after `rst_n` rises.
- R2: A low level on `mr_n` drives `sys_rst_n` low within four clock cycles and does not change `cause_stat`.
- R3: A rising or a falling edge on a refresh input reloads only its own watchdog. Refreshing both watchdogs every two ticks keeps `sys_rst_n` high indefinitely.
- R4: If the short watchdog is enabled and gets no refresh for WD1_TICKS ticks, `sys_rst_n` goes low and `cause_stat` is high.
- R5: With `lock_mode` = 0 and `wd1_float` = 1, the short watchdog never times out.
- R6: With `lock_mode` = 1, `wd1_float` has no effect and the short watchdog still times out.
- R7: If the long watchdog gets no refresh for WD2_TICKS ticks, `sys_rst_n` goes low and `cause_stat` goes low.
- R8: After a long-watchdog timeout, `cause_stat` returns high after exactly CLR_TICKS ticks, provided no further timeout occurs.
- R9: After the last cycle in which a reset cause is present, `sys_rst_n` stays low for RST_CYC more clock cycles. Both watchdog counts restart from zero when it rises.
- R10: If both watchdogs expire in the same cycle, `cause_stat` goes low.
- R11: A high level on `por_req` drives `sys_rst_n` low and sets `cause_stat` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| por_req | input | 1 | Power-on indication, active high |
| mr_n | input | 1 | Manual reset request, active low |
| lock_mode | input | 1 | 1 = a floating short-watchdog refresh cannot disable the short watchdog |
| wd1_kick | input | 1 | Short-watchdog refresh, either edge counts |
| wd1_float | input | 1 | 1 = short-watchdog refresh input is detected floating |
| wd2_kick | input | 1 | Long-watchdog refresh, either edge counts |
| sys_rst_n | output | 1 | System reset, active low |
| cause_stat | output | 1 | Last reset cause: 1 = short watchdog or power-on, 0 = long watchdog |

## Verification
The bench builds the block with a prescaler of 4 cycles per tick, a short timeout of 5 ticks, a long timeout of 12 ticks, a clear interval of 20 ticks and a reset width of 6 cycles. With these values every timeout and the self-clearing status happen within a few hundred cycles. The value 7 for the gap between the two timeouts lets the bench enable the short watchdog at a chosen tick, so that both watchdogs expire in the same cycle.

// File: rtl/wdsup_pkg.sv
// Shared definitions for the dual watchdog supervisor.
// Assumes: channel indices below are used consistently by the top and bench.
package wdsup_pkg;
    localparam int NCH      = 5;  // number of synchronized inputs
    localparam int CH_KICK1 = 0;  // short watchdog refresh
    localparam int CH_KICK2 = 1;  // long watchdog refresh
    localparam int CH_FLOAT = 2;  // short watchdog refresh floating flag
    localparam int CH_MR    = 3;  // manual reset request (active high here)
    localparam int CH_POR   = 4;  // power-on request
endpackage

// File: rtl/wdsup_sync.sv
// Two-flop synchronizer with a change detector.
// Assumes: din is asynchronous to clk; all stages reset to zero.
module wdsup_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic chg
);
    logic s1, s2, s3;

    // Purpose: shift the input through the synchronizer and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl = s2;
    assign chg = s2 ^ s3;
endmodule

// File: rtl/wdsup_dog.sv
// One watchdog timer counting reference ticks.
// Assumes: LIMIT >= 2; expire is a one-cycle pulse on the tick where the
// count would reach LIMIT; run and en low hold the count at zero.
module wdsup_dog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic en,
    input  logic kick,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expire = run && en && !kick && tick && (cnt == LAST);

    // Purpose: count ticks since the last refresh, clearing on hold or refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !en || kick) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    a_r3_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

    // Purpose: check the count never leaves its range.
    always @(posedge clk) begin
        if (rst_n) begin
            a_r4_cnt_range: assert (cnt < CW'(LIMIT)) else $error("count out of range");
        end
    end
endmodule

// File: rtl/wdsup_ctrl.sv
// Reset pulse generator and reset-cause status with self-clearing.
// Assumes: causes are synchronous single-cycle or level requests; the long
// watchdog wins over every other cause when updating status.
module wdsup_ctrl #(
    parameter int RST_CYC   = 8,
    parameter int CLR_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic por,
    input  logic mr,
    input  logic wd1_exp,
    input  logic wd2_exp,
    output logic active,
    output logic stat
);
    localparam int PCW = $clog2(RST_CYC + 1);
    localparam int CCW = $clog2(CLR_TICKS + 1);
    localparam logic [PCW-1:0] PLAST = PCW'(RST_CYC - 1);
    localparam logic [CCW-1:0] CLAST = CCW'(CLR_TICKS - 1);

    logic [PCW-1:0] pc;
    logic [CCW-1:0] cc;
    logic           trig;

    assign trig = por || mr || wd1_exp || wd2_exp;

    // Purpose: hold reset while a cause is present and for RST_CYC cycles after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            pc     <= '0;
        end else if (trig) begin
            active <= 1'b1;
            pc     <= '0;
        end else if (active) begin
            if (pc == PLAST) begin
                active <= 1'b0;
                pc     <= '0;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    // Purpose: record the reset cause and clear a long-watchdog mark after CLR_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 1'b1;
            cc   <= '0;
        end else if (wd2_exp) begin
            stat <= 1'b0;
            cc   <= '0;
        end else if (wd1_exp || por) begin
            stat <= 1'b1;
            cc   <= '0;
        end else if (!stat && tick) begin
            if (cc == CLAST) begin
                stat <= 1'b1;
                cc   <= '0;
            end else begin
                cc <= cc + 1'b1;
            end
        end
    end

    a_r2_mr_forces: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> active);

    a_r9_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(pc) == PLAST));

    a_r10_wd2_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wd2_exp |=> !stat);

    // Purpose: check the clear counter stays inside the interval.
    always @(posedge clk) begin
        if (rst_n) begin
            a_r8_cc_range: assert (cc < CCW'(CLR_TICKS)) else $error("clear count out of range");
        end
    end
endmodule

// File: rtl/wdsup_top.sv
// Dual watchdog reset supervisor: input synchronizers, reference tick
// prescaler, two watchdogs and the reset/status controller.
// Assumes: lock_mode is a static strap; all other inputs may be asynchronous.
module wdsup_top #(
    parameter int TICK_DIV  = 100000,
    parameter int WD1_TICKS = 1600,
    parameter int WD2_TICKS = 60000,
    parameter int CLR_TICKS = 1000,
    parameter int RST_CYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_req,
    input  logic mr_n,
    input  logic lock_mode,
    input  logic wd1_kick,
    input  logic wd1_float,
    input  logic wd2_kick,
    output logic sys_rst_n,
    output logic cause_stat
);
    import wdsup_pkg::*;

    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [NCH-1:0] raw, lvl, chg;
    logic [PW-1:0]  pre;
    logic           tick, active, wd1_en, wd1_exp, wd2_exp;

    assign raw[CH_KICK1] = wd1_kick;
    assign raw[CH_KICK2] = wd2_kick;
    assign raw[CH_FLOAT] = wd1_float;
    assign raw[CH_MR]    = ~mr_n;
    assign raw[CH_POR]   = por_req;

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        wdsup_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .lvl  (lvl[i]),
            .chg  (chg[i])
        );
    end

    // Purpose: free-running prescaler producing one tick every TICK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) pre <= '0;
        else                pre <= pre + 1'b1;
    end
    assign tick = (pre == PRE_LAST);

    assign wd1_en = lock_mode || !lvl[CH_FLOAT];

    wdsup_dog #(.LIMIT(WD1_TICKS)) u_wd1 (
        .clk(clk), .rst_n(rst_n), .run(!active), .en(wd1_en),
        .kick(chg[CH_KICK1]), .tick(tick), .expire(wd1_exp)
    );

    wdsup_dog #(.LIMIT(WD2_TICKS)) u_wd2 (
        .clk(clk), .rst_n(rst_n), .run(!active), .en(1'b1),
        .kick(chg[CH_KICK2]), .tick(tick), .expire(wd2_exp)
    );

    wdsup_ctrl #(.RST_CYC(RST_CYC), .CLR_TICKS(CLR_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .por(lvl[CH_POR]), .mr(lvl[CH_MR]),
        .wd1_exp(wd1_exp), .wd2_exp(wd2_exp),
        .active(active), .stat(cause_stat)
    );

    assign sys_rst_n = !active;

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_mode && lvl[CH_FLOAT]) |-> !wd1_exp);

    a_r7_stat_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cause_stat) |-> $past(wd2_exp));

    a_r11_por_reset: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[CH_POR] |=> (!sys_rst_n && cause_stat));
endmodule

// File: tb/wdsup_top_test.sv
module wdsup_top_test;
    localparam int DIV = 4;
    localparam int W1  = 5;
    localparam int W2  = 12;
    localparam int CLR = 20;
    localparam int RC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_req = 1'b0, mr_n = 1'b1, lock_mode = 1'b0;
    logic wd1_kick = 1'b0, wd1_float = 1'b0, wd2_kick = 1'b0;
    logic sys_rst_n, cause_stat;

    int errs = 0, checks = 0, cyc = 0;
    bit k1_on = 1'b0, k2_on = 1'b0, cmp_on = 1'b0;

    always #5 clk = ~clk;

    wdsup_top #(.TICK_DIV(DIV), .WD1_TICKS(W1), .WD2_TICKS(W2),
                .CLR_TICKS(CLR), .RST_CYC(RC)) uut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .mr_n(mr_n),
        .lock_mode(lock_mode), .wd1_kick(wd1_kick), .wd1_float(wd1_float),
        .wd2_kick(wd2_kick), .sys_rst_n(sys_rst_n), .cause_stat(cause_stat)
    );

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int  m_s1[5], m_s2[5], m_s3[5];
    int  m_pre = 0, m_c1 = 0, m_c2 = 0, m_pc = 0, m_cc = 0;
    bit  m_act = 1'b1, m_stat = 1'b1, m_both = 1'b0;

    always @(posedge clk) begin
        int  inb[5];
        bit  tk, k1, k2, en1, e1, e2, trig;
        cyc++;
        inb[0] = int'(wd1_kick); inb[1] = int'(wd2_kick); inb[2] = int'(wd1_float);
        inb[3] = int'(!mr_n);    inb[4] = int'(por_req);
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; end
            m_pre = 0; m_c1 = 0; m_c2 = 0; m_pc = 0; m_cc = 0; m_act = 1; m_stat = 1;
        end else begin
            tk  = (m_pre == DIV - 1);
            k1  = (m_s2[0] != m_s3[0]);
            k2  = (m_s2[1] != m_s3[1]);
            en1 = lock_mode || (m_s2[2] == 0);
            e1  = !m_act && en1 && !k1 && tk && (m_c1 == W1 - 1);
            e2  = !m_act && !k2 && tk && (m_c2 == W2 - 1);
            if (e1 && e2) m_both = 1;
            trig = e1 || e2 || (m_s2[3] != 0) || (m_s2[4] != 0);
            if (e2) begin m_stat = 0; m_cc = 0; end
            else if (e1 || m_s2[4] != 0) begin m_stat = 1; m_cc = 0; end
            else if (!m_stat && tk) begin
                if (m_cc == CLR - 1) begin m_stat = 1; m_cc = 0; end else m_cc++;
            end
            if (m_act || !en1 || k1) m_c1 = 0; else if (tk) m_c1 = (m_c1 + 1) % W1;
            if (m_act || k2) m_c2 = 0; else if (tk) m_c2 = (m_c2 + 1) % W2;
            if (trig) begin m_act = 1; m_pc = 0; end
            else if (m_act) begin
                if (m_pc == RC - 1) begin m_act = 0; m_pc = 0; end else m_pc++;
            end
            m_pre = tk ? 0 : m_pre + 1;
            for (int i = 0; i < 5; i++) begin m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = inb[i]; end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R9 sys_rst_n vs model", int'(sys_rst_n), int'(!m_act));
            chk("R7 cause_stat vs model", int'(cause_stat), int'(m_stat));
        end
    end

    // Background refresh generators: toggle every 8 cycles (two ticks).
    int kc1 = 0, kc2 = 0;
    always @(negedge clk) begin
        if (k1_on) begin kc1++; if (kc1 == 8) begin kc1 = 0; wd1_kick = ~wd1_kick; end end
        if (k2_on) begin kc2++; if (kc2 == 8) begin kc2 = 0; wd2_kick = ~wd2_kick; end end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rst(bit lvl, int maxc, output bit seen);
        seen = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (sys_rst_n == lvl) begin seen = 1; break; end
        end
    endtask

    task automatic quiet(int n, output bit low_seen);
        low_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!sys_rst_n) low_seen = 1;
        end
    endtask

    task automatic low_len(output int len);
        len = 0;
        while (!sys_rst_n && len < 1000) begin @(negedge clk); len++; end
    endtask

    initial begin
        bit seen;
        int len;
        cycles(4);
        cmp_on = 1;
        chk("R1 reset holds sys_rst_n low", int'(sys_rst_n), 0);
        chk("R1 reset status high", int'(cause_stat), 1);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 still low after release", int'(sys_rst_n), 0);

        // R3: regular refreshes keep the system out of reset.
        k1_on = 1; k2_on = 1;
        wait_rst(1'b1, 100, seen);
        chk("R9 initial pulse ends", int'(seen), 1);
        quiet(300, seen);
        chk("R3 refreshed system stays up", int'(seen), 0);

        // R4: short watchdog starved.
        k1_on = 0;
        wait_rst(1'b0, 200, seen);
        chk("R4 short timeout resets", int'(seen), 1);
        chk("R4 short timeout status high", int'(cause_stat), 1);
        k1_on = 1;
        low_len(len);
        chk("R9 pulse width at least RST_CYC", int'(len >= RC), 1);

        // R5: floating refresh with lock low disables the short watchdog.
        wd1_float = 1; k1_on = 0;
        quiet(200, seen);
        chk("R5 disabled short watchdog quiet", int'(seen), 0);

        // R6: lock high overrides the floating flag.
        lock_mode = 1;
        wait_rst(1'b0, 200, seen);
        chk("R6 lock keeps short watchdog active", int'(seen), 1);
        chk("R6 status high", int'(cause_stat), 1);
        lock_mode = 0; wd1_float = 0; k1_on = 1;
        wait_rst(1'b1, 100, seen);

        // R7/R8: long watchdog starved, then status self-clears.
        k2_on = 0;
        wait_rst(1'b0, W2 * DIV + 100, seen);
        chk("R7 long timeout resets", int'(seen), 1);
        chk("R7 long timeout status low", int'(cause_stat), 0);
        k2_on = 1;
        cycles((CLR - 1) * DIV);
        chk("R8 status still low before interval", int'(cause_stat), 0);
        cycles(DIV + 1);
        chk("R8 status cleared after interval", int'(cause_stat), 1);

        // R2: manual reset.
        wait_rst(1'b1, 100, seen);
        mr_n = 0; cycles(3); mr_n = 1;
        cycles(1);
        chk("R2 manual reset drives low", int'(sys_rst_n), 0);
        chk("R2 manual reset keeps status", int'(cause_stat), 1);
        low_len(len);
        chk("R9 manual pulse width", int'(len >= RC), 1);

        // R11: power-on request after a long timeout marks status high.
        k2_on = 0;
        wait_rst(1'b0, W2 * DIV + 100, seen);
        k2_on = 1;
        wait_rst(1'b1, 100, seen);
        chk("R11 precondition status low", int'(cause_stat), 0);
        por_req = 1; cycles(2); por_req = 0;
        cycles(2);
        chk("R11 power-on drives low", int'(sys_rst_n), 0);
        chk("R11 power-on status high", int'(cause_stat), 1);
        wait_rst(1'b1, 100, seen);

        // R10: align both watchdogs to expire on the same tick.
        k1_on = 0; k2_on = 0; wd1_float = 1;
        cycles(20);
        wait_rst(1'b1, 200, seen);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (m_c2 == W2 - W1 && m_pre == 0 && !m_act) break;
        end
        wd1_float = 0;
        wait_rst(1'b0, 200, seen);
        chk("R10 both expire same cycle", int'(m_both), 1);
        chk("R10 long watchdog wins status", int'(cause_stat), 0);
        cycles(10);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++; errs++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule